// File: doc/BRIEF.md
# UART Serial Engine with Timed Break

This block is the bit-level transmit and receive engine of a UART. It takes one character at a time from a transmit handshake and sends it on a serial line. It also watches the receive line and delivers each character it receives, together with its parity and framing error flags. A 10-bit line-control register holds the character format, the enables, a modem RTS level, an internal loopback switch and a break request. Two static inputs set the baud rate and the length of a break.

The baud rate comes from a two-stage divider that produces a sample tick. Each bit spans 13 ticks. The receiver starts a character on a falling edge of the line and samples every bit at its middle tick. When software sets the break bit, the transmitter holds the line low for a number of bit periods taken from the break-count input. At the end it pulses a break-done event and clears the break bit by itself. A busy output stays high while any frame or break is in progress, so software can wait for it to drop before it changes the divisor.

Top module: `uart_serial_engine`

## Requirements
- R1: A transmitted frame has these parts, in order: a low start bit; the data bits, LSB first (8 when control bit 2 is set, else 7); a parity bit when control bit 4 is set; then one high stop bit, or two when control bit 3 is set. The parity bit is chosen so that the data bits plus the parity bit hold an even number of ones, or an odd number when control bit 5 is set.
- R2: The divisor word has two fields. Bits 19:16 hold the predivisor minus one and bits 9:0 hold the baud divisor minus one. One bit lasts (pre+1)*13*(div+1) clock cycles.
- R3: `tx_ready` is asserted only while control bit 0 is set, the transmitter is idle and no break is requested. While control bit 0 is clear, no character is taken and `txd` stays high.
- R4: When control bit 1 is set, a falling edge on the line starts reception and each bit is sampled at tick 6 of 13. Each received character gives a one-cycle `rx_valid` with `rx_data`, and bit 7 is 0 in 7-bit mode. While control bit 1 is clear, no character is delivered.
- R5: A received parity bit that does not match the selected parity sets `rx_perr`, and `par_err_evt` pulses together with `rx_valid`.
- R6: A first stop bit that samples low sets `rx_ferr`, and `frm_err_evt` pulses together with `rx_valid`.
- R7: A start bit that is no longer low at its middle tick is rejected, and no character is delivered.
- R8: When control bit 7 is set, the receiver sees the transmitter's output and `txd` is held high.
- R9: `rts` follows control bit 6.
- R10: Setting control bit 9 holds the transmit line low for `break_cnt` bit periods. A count of 0 acts as 1. At the end, `brk_done` pulses once, and control bit 9 reads 0 from the same cycle. No character is taken while bit 9 is set.
- R11: `busy` is high from the acceptance of a character or the start of a break until that frame or break ends, and also while a reception is in progress. When `busy` is low, `txd` is high.
- R12: After a character is received, if no new start bit arrives within TIMEOUT_BITS bit periods, `rx_timeout` pulses exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the line-control register |
| cfg_wdata | input | 10 | Line-control write value |
| cfg_q | output | 10 | Line-control register contents |
| divisor | input | 20 | Predivisor (19:16) and baud divisor (9:0), each minus one |
| break_cnt | input | 16 | Break length in bit periods |
| tx_valid | input | 1 | Transmit character offered |
| tx_data | input | 8 | Transmit character |
| tx_ready | output | 1 | Transmitter takes the offered character this cycle |
| rx_valid | output | 1 | One-cycle pulse: received character ready |
| rx_data | output | 8 | Received character |
| rx_perr | output | 1 | Parity error flag of the last character |
| rx_ferr | output | 1 | Framing error flag of the last character |
| busy | output | 1 | Frame, break or reception in progress |
| brk_done | output | 1 | Break finished pulse |
| par_err_evt | output | 1 | Parity error event pulse |
| frm_err_evt | output | 1 | Framing error event pulse |
| rx_timeout | output | 1 | Receive idle timeout pulse |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts | output | 1 | Request-to-send level |

## Verification
A table of format vectors sends characters in 7-bit and 8-bit width, with parity off, even and odd, and with one and two stop bits. Each transmitted frame is compared bit by bit, which shows whether the data length, parity sense and stop count are each decoded. The same formats are then driven into the receiver, once cleanly and once with a flipped parity bit or a low stop bit, which separates the two error flags from each other and from a good character. Directed cases follow. One uses an uneven divisor, which shows whether both divider fields set the bit period. The others cover a short start-bit glitch, disabled directions, loopback, a timed break and the idle timeout.

// File: rtl/uart_serial_engine.sv
module uart_serial_engine #(
  parameter int PRE_W        = 4,
  parameter int DIV_W        = 10,
  parameter int BRK_W        = 16,
  parameter int OVS          = 13,
  parameter int TIMEOUT_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [9:0]       cfg_wdata,
  output logic [9:0]       cfg_q,
  input  logic [19:0]      divisor,
  input  logic [BRK_W-1:0] break_cnt,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             busy,
  output logic             brk_done,
  output logic             par_err_evt,
  output logic             frm_err_evt,
  output logic             rx_timeout,
  output logic             txd,
  input  logic             rxd,
  output logic             rts
);
  localparam int TW       = $clog2(OVS);
  localparam int TO_TICKS = TIMEOUT_BITS * OVS;
  localparam int TO_W     = $clog2(TO_TICKS + 1);
  localparam logic [TW-1:0] TC_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] TC_MID  = TW'(OVS / 2);

  typedef enum logic [1:0] {T_IDLE, T_FRAME, T_BREAK} tx_st_t;
  typedef enum logic {R_IDLE, R_FRAME} rx_st_t;

  logic [9:0] lcr;
  wire tx_en = lcr[0];
  wire rx_en = lcr[1];
  wire d8    = lcr[2];
  wire st2   = lcr[3];
  wire pen   = lcr[4];
  wire podd  = lcr[5];
  wire lb    = lcr[7];
  wire brk_q = lcr[9];

  wire [3:0] nd      = d8 ? 4'd8 : 4'd7;
  wire [7:0] dmask   = d8 ? 8'hFF : 8'h7F;
  wire [3:0] tx_last = nd + {3'd0, pen} + (st2 ? 4'd2 : 4'd1);
  wire [3:0] rx_stop = nd + {3'd0, pen} + 4'd1;

  // baud tick
  logic [PRE_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  wire [PRE_W-1:0] pre_lim = divisor[16 +: PRE_W];
  wire [DIV_W-1:0] div_lim = divisor[DIV_W-1:0];
  wire tick = (pre_cnt == pre_lim) && (div_cnt == div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_cnt == pre_lim) begin
      pre_cnt <= '0;
      div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end

  // transmitter
  tx_st_t           tx_st;
  logic [3:0]       tx_idx;
  logic [TW-1:0]    tx_tc;
  logic [7:0]       tx_buf;
  logic [BRK_W-1:0] brk_left;
  logic             tx_line;

  wire brk_end = (tx_st == T_BREAK) && tick && (tx_tc == TC_LAST) && (brk_left == 1);
  wire [3:0] tx_sel = tx_idx - 4'd1;
  wire tx_par = ^(tx_buf & dmask) ^ podd;

  assign tx_ready = (tx_st == T_IDLE) && tx_en && !brk_q;

  always_comb begin
    tx_line = 1'b1;
    if (tx_st == T_BREAK) tx_line = 1'b0;
    else if (tx_st == T_FRAME) begin
      if (tx_idx == 4'd0)                tx_line = 1'b0;
      else if (tx_idx <= nd)             tx_line = tx_buf[tx_sel[2:0]];
      else if (pen && tx_idx == nd + 1)  tx_line = tx_par;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_st    <= T_IDLE;
      tx_idx   <= '0;
      tx_tc    <= '0;
      tx_buf   <= '0;
      brk_left <= '0;
      brk_done <= 1'b0;
    end else begin
      brk_done <= brk_end;
      case (tx_st)
        T_IDLE:
          if (brk_q) begin
            tx_st    <= T_BREAK;
            tx_tc    <= '0;
            brk_left <= (break_cnt == '0) ? BRK_W'(1) : break_cnt;
          end else if (tx_valid && tx_ready) begin
            tx_st  <= T_FRAME;
            tx_buf <= tx_data;
            tx_idx <= '0;
            tx_tc  <= '0;
          end
        T_FRAME:
          if (tick) begin
            if (tx_tc == TC_LAST) begin
              tx_tc <= '0;
              if (tx_idx == tx_last) tx_st <= T_IDLE;
              else tx_idx <= tx_idx + 4'd1;
            end else tx_tc <= tx_tc + 1'b1;
          end
        default:
          if (tick) begin
            if (tx_tc == TC_LAST) begin
              tx_tc <= '0;
              if (brk_left == 1) tx_st <= T_IDLE;
              else brk_left <= brk_left - 1'b1;
            end else tx_tc <= tx_tc + 1'b1;
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lcr <= '0;
    else begin
      if (cfg_we) lcr <= cfg_wdata;
      if (brk_end) lcr[9] <= 1'b0;
    end
  end

  assign cfg_q = lcr;
  assign rts   = lcr[6];
  assign txd   = lb ? 1'b1 : tx_line;

  // receiver
  wire rx_src = lb ? tx_line : rxd;
  logic rs1, rs2, rs_prev;
  rx_st_t        rx_st;
  logic [3:0]    rx_idx;
  logic [TW-1:0] rx_tc;
  logic [7:0]    rx_sh;
  logic          rx_pbit;
  logic          to_armed;
  logic [TO_W-1:0] to_cnt;

  wire fall = rs_prev && !rs2;
  wire [3:0] rx_sel = rx_idx - 4'd1;
  wire [7:0] rx_word = rx_sh & dmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1 <= 1'b1; rs2 <= 1'b1; rs_prev <= 1'b1;
      rx_st <= R_IDLE; rx_idx <= '0; rx_tc <= '0;
      rx_sh <= '0; rx_pbit <= 1'b0;
      rx_valid <= 1'b0; rx_data <= '0; rx_perr <= 1'b0; rx_ferr <= 1'b0;
      to_armed <= 1'b0; to_cnt <= '0; rx_timeout <= 1'b0;
    end else begin
      rs1 <= rx_src; rs2 <= rs1; rs_prev <= rs2;
      rx_valid   <= 1'b0;
      rx_timeout <= 1'b0;
      if (rx_st == R_IDLE) begin
        if (fall && rx_en) begin
          rx_st <= R_FRAME; rx_idx <= '0; rx_tc <= '0; to_armed <= 1'b0;
        end else if (to_armed && tick) begin
          if (to_cnt == TO_W'(TO_TICKS - 1)) begin
            rx_timeout <= 1'b1;
            to_armed   <= 1'b0;
          end else to_cnt <= to_cnt + 1'b1;
        end
      end else if (tick) begin
        rx_tc <= (rx_tc == TC_LAST) ? '0 : rx_tc + 1'b1;
        if (rx_tc == TC_LAST) rx_idx <= rx_idx + 4'd1;
        if (rx_tc == TC_MID) begin
          if (rx_idx == 4'd0) begin
            if (rs2) rx_st <= R_IDLE;
          end else if (rx_idx <= nd) begin
            rx_sh[rx_sel[2:0]] <= rs2;
          end else if (rx_idx < rx_stop) begin
            rx_pbit <= rs2;
          end else begin
            rx_st    <= R_IDLE;
            rx_valid <= 1'b1;
            rx_data  <= rx_word;
            rx_perr  <= pen && (rx_pbit != (^rx_word ^ podd));
            rx_ferr  <= !rs2;
            to_armed <= 1'b1;
            to_cnt   <= '0;
          end
        end
      end
    end
  end

  assign par_err_evt = rx_valid && rx_perr;
  assign frm_err_evt = rx_valid && rx_ferr;
  assign busy = (tx_st != T_IDLE) || (rx_st != R_IDLE);
endmodule

module uart_serial_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [9:0] cfg_q,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_valid,
  input logic       rx_timeout,
  input logic       busy,
  input logic       brk_done,
  input logic       par_err_evt,
  input logic       txd
);
  AST_TXREADY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) tx_ready |-> cfg_q[0]); // R3
  AST_PERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n) par_err_evt |-> cfg_q[4]); // R5
  AST_LOOPBACK_TXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cfg_q[7] |-> txd); // R8
  AST_BRK_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) brk_done |-> !cfg_q[9]); // R10
  AST_NO_ACCEPT_IN_BRK: assert property (@(posedge clk) disable iff (!rst_n) cfg_q[9] |-> !tx_ready); // R10
  AST_BRK_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) brk_done |=> !brk_done); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> busy); // R11
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> txd); // R11
  AST_RX_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({rx_valid, rx_timeout})); // R12
endmodule

bind uart_serial_engine uart_serial_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_timeout(rx_timeout), .busy(busy), .brk_done(brk_done),
  .par_err_evt(par_err_evt), .txd(txd)
);

// File: tb/uart_serial_engine_tb.sv
module uart_serial_engine_tb;
  localparam int BITC = 13;
  localparam int NV   = 8;
  // {podd, pen, st2, d8}, data, inj (0 none, 1 bad parity, 2 low stop)
  localparam logic [13:0] VEC [NV] = '{
    {4'b0001, 8'hA5, 2'd0},
    {4'b0000, 8'hDA, 2'd0},
    {4'b0101, 8'h3C, 2'd0},
    {4'b1101, 8'h3C, 2'd0},
    {4'b0011, 8'hFF, 2'd0},
    {4'b0101, 8'h81, 2'd1},
    {4'b0001, 8'h42, 2'd2},
    {4'b1100, 8'h07, 2'd0}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_q;
  logic [19:0] divisor = '0;
  logic [15:0] break_cnt = 16'd1;
  logic tx_valid = 0;
  logic [7:0] tx_data = '0;
  logic tx_ready, rx_valid, rx_perr, rx_ferr, busy, brk_done;
  logic par_err_evt, frm_err_evt, rx_timeout, txd, rts;
  logic rxd = 1;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  int rx_n = 0, pe_n = 0, fe_n = 0, bk_n = 0, to_n = 0;
  logic [7:0] last_d;
  logic last_pe, last_fe;
  logic done = 0;

  always #4 clk = ~clk;

  uart_serial_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .divisor(divisor), .break_cnt(break_cnt), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .busy(busy), .brk_done(brk_done), .par_err_evt(par_err_evt),
    .frm_err_evt(frm_err_evt), .rx_timeout(rx_timeout), .txd(txd), .rxd(rxd), .rts(rts)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_n++; last_d = rx_data; last_pe = rx_perr; last_fe = rx_ferr; end
    if (par_err_evt) pe_n++;
    if (frm_err_evt) fe_n++;
    if (brk_done) bk_n++;
    if (rx_timeout) to_n++;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [9:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  function automatic int build(input logic [3:0] c, input logic [7:0] d, input logic [1:0] inj,
                               output logic [11:0] b);
    int nd = c[0] ? 8 : 7;
    int k;
    logic [7:0] m = c[0] ? 8'hFF : 8'h7F;
    b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < nd; i++) b[1+i] = d[i];
    k = 1 + nd;
    if (c[2]) begin b[k] = ^(d & m) ^ c[3] ^ (inj == 2'd1); k++; end
    b[k] = (inj == 2'd2) ? 1'b0 : 1'b1; k++;
    if (c[1]) begin b[k] = 1'b1; k++; end
    return k;
  endfunction

  task automatic send_tx(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic tx_frame(input logic [7:0] d, input int n, output logic [11:0] got);
    got = '1;
    send_tx(d);
    repeat (6) @(negedge clk);
    got[0] = txd;
    for (int i = 1; i < n; i++) begin
      repeat (BITC) @(negedge clk);
      got[i] = txd;
    end
  endtask

  task automatic rx_drive(input logic [11:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxd = 1;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] exp_b, got_b;
    int n, base, base2, lows, run;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0, "R11 reset idle", {txd, busy}, 2'b10);
    chk(tx_ready === 1'b0 && cfg_q === 10'd0 && rts === 1'b0, "R3 reset", {tx_ready, cfg_q}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [3:0] c = VEC[v][13:10];
      logic [7:0] d = VEC[v][9:2];
      logic [1:0] inj = VEC[v][1:0];
      logic [7:0] m = c[0] ? 8'hFF : 8'h7F;
      wr_cfg({4'b0, c[3], c[2], c[1], c[0], 2'b11});
      n = build(c, d, 2'd0, exp_b);
      tx_frame(d, n, got_b);
      chk(got_b === exp_b, "R1 tx frame", got_b, exp_b);
      repeat (20) @(negedge clk);
      n = build(c, d, inj, exp_b);
      base = rx_n; base2 = pe_n + fe_n;
      rx_drive(exp_b, n);
      chk(rx_n == base + 1 && last_d === (d & m), "R4 rx data", last_d, d & m);
      chk(last_pe === (inj == 2'd1), "R5 parity flag", last_pe, inj == 2'd1);
      chk(last_fe === (inj == 2'd2), "R6 framing flag", last_fe, inj == 2'd2);
      chk(pe_n + fe_n == base2 + (inj != 0), "R5 R6 events", pe_n + fe_n, base2 + (inj != 0));
      repeat (80) @(negedge clk);
    end

    // R2 bit period: pre=1, div=2 -> 78 clocks per bit; 8-bit 0x0F
    divisor = {4'd1, 6'd0, 10'd2};
    wr_cfg(10'b0000000111);
    send_tx(8'h0F);
    while (txd) @(negedge clk);
    while (!txd) @(negedge clk);
    run = 0;
    while (txd && run < 2000) begin run++; @(negedge clk); end
    chk(run == 312, "R2 high run", run, 312);
    run = 0;
    while (!txd && run < 2000) begin run++; @(negedge clk); end
    chk(run == 312, "R2 low run", run, 312);
    while (busy) @(negedge clk);
    divisor = '0;
    repeat (100) @(negedge clk);

    // R7 glitch on start
    wr_cfg(10'b0000000111);
    base = rx_n;
    rxd = 0; repeat (3) @(negedge clk); rxd = 1;
    repeat (300) @(negedge clk);
    chk(rx_n == base && busy === 1'b0, "R7 glitch rejected", rx_n - base, 0);

    // R4 rx disabled
    wr_cfg(10'b0000000101);
    base = rx_n;
    n = build(4'b0001, 8'h55, 2'd0, exp_b);
    rx_drive(exp_b, n);
    repeat (50) @(negedge clk);
    chk(rx_n == base, "R4 rx disabled", rx_n - base, 0);

    // R3 tx disabled
    wr_cfg(10'b0000000110);
    tx_valid = 1; tx_data = 8'h00; lows = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tx_ready || !txd) lows++;
    end
    tx_valid = 0;
    chk(lows == 0, "R3 tx disabled", lows, 0);

    // R9 rts
    wr_cfg(10'b0001000000);
    chk(rts === 1'b1, "R9 rts high", rts, 1);
    wr_cfg(10'b0000000000);
    chk(rts === 1'b0, "R9 rts low", rts, 0);

    // R8 loopback, then R12 timeout
    wr_cfg(10'b0010000111);
    base = rx_n; base2 = to_n; lows = 0;
    send_tx(8'h96);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!txd) lows++;
    end
    chk(lows == 0, "R8 txd held high", lows, 0);
    chk(rx_n == base + 1 && last_d === 8'h96, "R8 loopback data", last_d, 8'h96);
    repeat (300) @(negedge clk);
    chk(to_n == base2 + 1, "R12 timeout once", to_n - base2, 1);

    // R10 break of 3 bit periods
    wr_cfg(10'b0000000111);
    break_cnt = 16'd3;
    base = bk_n;
    wr_cfg(10'b1000000111);
    run = 0;
    while (txd && run < 100) begin run++; @(negedge clk); end
    run = 0;
    while (!txd && run < 1000) begin run++; @(negedge clk); end
    chk(run == 3 * BITC, "R10 break length", run, 3 * BITC);
    repeat (3) @(negedge clk);
    chk(bk_n == base + 1, "R10 break done pulse", bk_n - base, 1);
    chk(cfg_q[9] === 1'b0 && busy === 1'b0, "R10 R11 bit cleared idle", {cfg_q[9], busy}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule